// File: doc/BRIEF.md
# Memory Bus Transfer Sequencer

This block is the master side of a plain single-transfer memory bus. A client presents one operation at a time (read or write, an address and, for writes, a data word). The sequencer then runs a bus cycle on separate address, write-data, read-data, read-strobe and write-strobe lines and answers with a one-clock completion pulse. For reads that pulse carries the returned word.

Every cycle has three phases. In the setup clock the address goes out and the strobe for the operation rises. In the wait phase the strobe is held while the memory's ready line is sampled. In the finish clock the strobe drops and completion is signalled. A fast memory holds ready high and finishes in three clocks. A slow memory holds ready low and stretches the wait phase one clock at a time. A memory that never answers is cut off after a parameterised number of stalled clocks, and the cycle then ends with an error flag.

States: `ST_IDLE` (ready for a request), `ST_SETUP` (first clock), `ST_WAIT` (strobe held, ready sampled), `ST_FINISH` (strobe low, completion). Transitions: IDLE→SETUP on an accepted request. SETUP→WAIT always. WAIT→FINISH when ready is high (normal end) or when the stall limit is reached (abort). WAIT→WAIT while ready is low and under the limit. FINISH→IDLE always.

Top module: `membus_seq`

## Requirements
- R1: A request (`req_valid` high) is taken only in a clock where `req_ready` is high, and `req_ready` is high only in the idle state. A request raised while a cycle is running is ignored: the bus address does not change and no second cycle follows.
- R2: A read with `mem_ready` high in the first wait clock keeps `bus_rd` high for exactly two clocks (setup and wait) and raises `rsp_done` in the third clock after acceptance, with `bus_rd` low.
- R3: A write with `mem_ready` high in the first wait clock keeps `bus_wr` high for exactly two clocks and raises `rsp_done` in the third clock, with `bus_wr` low.
- R4: Each wait clock with `mem_ready` low adds one clock to the cycle. Read data is taken from `mem_rdata` in the first wait clock where `mem_ready` is high, and values present in stalled clocks are not used.
- R5: `bus_rd` and `bus_wr` are never high together. Both are low in reset, in idle and in the finish clock.
- R6: `rsp_done` lasts exactly one clock per cycle. With it, `rsp_rdata` holds the captured word for a completed read, and it holds zero for writes and aborted cycles.
- R7: After `WAIT_LIMIT` (default 16) consecutive wait clocks with `mem_ready` low, the cycle ends: `rsp_done` and `rsp_err` are high in the clock after the last stalled clock. `rsp_err` is low for every cycle that ends normally.
- R8: From the setup clock through the finish clock, `bus_addr` holds the request address, and for writes `bus_wdata` holds the request data. In idle both are zero, and `bus_wdata` is zero throughout a read.
- R9: `mem_ready` is ignored during the setup clock. Holding it high there does not shorten the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Cycle aborted by stall limit (valid with done) |
| rsp_rdata | output | DATA_W | Read result (valid with done) |
| bus_addr | output | ADDR_W | Memory address bus |
| bus_wdata | output | DATA_W | Memory write data bus |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| mem_ready | input | 1 | Memory ready, sampled in the wait phase |
| mem_rdata | input | DATA_W | Memory read data bus |

## Verification
Reads and writes are run with zero stalls, with a random number of stalls, with one stall short of the limit and with exactly the limit. This separates a three-clock cycle from a stretched one, and a late normal end from an abort. During stalled clocks the memory model drives the complement of the correct word on the read-data bus, so capture in the wrong clock shows up as a wrong value. Ready held high in the setup clock separates a sequencer that samples ready only in the wait phase from one that samples it early. A request raised while busy separates correct ignoring from a re-latched address or an extra cycle.

// File: rtl/membus_pkg.sv
package membus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_t;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } bus_op_t;

endpackage

// File: rtl/membus_stall_timer.sv
module membus_stall_timer #(
    parameter int WAIT_LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic stall,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (stall && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = stall && (cnt_q == LAST);

endmodule

// File: rtl/membus_xfer_regs.sv
module membus_xfer_regs
    import membus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  bus_op_t           op_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] rdata_in,
    output bus_op_t           op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (load) begin
            op_q    <= op_in;
            addr_q  <= addr_in;
            wdata_q <= (op_in == OP_WRITE) ? wdata_in : '0;
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= rdata_in;
        end
    end

endmodule

// File: rtl/membus_seq.sv
module membus_seq
    import membus_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int WAIT_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    seq_state_t state_q, state_d;
    logic       err_q, err_d;
    logic       accept;
    logic       stall;
    logic       expired;
    logic       capture;
    bus_op_t    op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign stall   = (state_q == ST_WAIT) && !mem_ready;
    assign capture = (state_q == ST_WAIT) && mem_ready && (op_q == OP_READ);

    membus_stall_timer #(
        .WAIT_LIMIT(WAIT_LIMIT)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (state_q != ST_WAIT),
        .stall  (stall),
        .expired(expired)
    );

    membus_xfer_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .op_in   (req_write ? OP_WRITE : OP_READ),
        .addr_in (req_addr),
        .wdata_in(req_wdata),
        .capture (capture),
        .rdata_in(mem_rdata),
        .op_q    (op_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .rdata_q (rdata_q)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_SETUP;
                    err_d   = 1'b0;
                end
            end
            ST_SETUP: state_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_ready) begin
                    state_d = ST_FINISH;
                end else if (expired) begin
                    state_d = ST_FINISH;
                    err_d   = 1'b1;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_done  = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_SETUP, ST_WAIT: begin
                bus_addr  = addr_q;
                bus_wdata = wdata_q;
                bus_rd    = (op_q == OP_READ);
                bus_wr    = (op_q == OP_WRITE);
            end
            ST_FINISH: begin
                bus_addr  = addr_q;
                bus_wdata = wdata_q;
                rsp_done  = 1'b1;
                rsp_err   = err_q;
                rsp_rdata = err_q ? '0 : rdata_q;
            end
            default: req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/membus_seq_chk.sv
module membus_seq_chk #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int WAIT_LIMIT = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr
);
    localparam int SC_W = $clog2(WAIT_LIMIT + 3);

    logic [SC_W-1:0] strobe_cnt;

    always_ff @(posedge clk) begin
        if (rst || !(bus_rd || bus_wr)) begin
            strobe_cnt <= '0;
        end else if (strobe_cnt != {SC_W{1'b1}}) begin
            strobe_cnt <= strobe_cnt + 1'b1;
        end
    end

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!bus_rd && !bus_wr && !rsp_done));

    assert_accept_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (bus_rd || bus_wr));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    assert_done_strobe_low_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (!bus_rd && !bus_wr));

    assert_rd_end_done_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_rd) |-> rsp_done);

    assert_wr_end_done_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_wr) |-> rsp_done);

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && $past(bus_rd || bus_wr)) |-> $stable(bus_addr));

    assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && $past(bus_wr)) |-> $stable(bus_wdata));

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_done);

    always_ff @(posedge clk) begin
        if (!rst) begin
            assert_stall_bound_R7: assert (int'(strobe_cnt) <= WAIT_LIMIT + 1);
        end
    end

endmodule

bind membus_seq membus_seq_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WAIT_LIMIT(WAIT_LIMIT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_done (rsp_done),
    .rsp_err  (rsp_err),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr)
);

// File: tb/tb_membus_seq.sv
module tb_membus_seq;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 32;
    localparam int WAIT_LIMIT = 16;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              req_ready;
    logic              rsp_done;
    logic              rsp_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_rd;
    logic              bus_wr;
    logic              mem_ready;
    logic [DATA_W-1:0] mem_rdata;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    membus_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .WAIT_LIMIT(WAIT_LIMIT)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_ready(req_ready),
        .rsp_done (rsp_done),
        .rsp_err  (rsp_err),
        .rsp_rdata(rsp_rdata),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .mem_ready(mem_ready),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a, ~a} ^ 32'h5A3C_0F96;
    endfunction

    function automatic int exp_len(input int stalls);
        return (stalls < WAIT_LIMIT) ? stalls + 3 : WAIT_LIMIT + 2;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle. stalls: ready-low wait clocks before ready. early_rdy: ready high in setup.
    // poke: raise a second request while busy.
    task automatic run_op(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input int stalls, input bit early_rdy, input bit poke);
        int cyc;
        int strobe_clks;
        bit done_seen;
        @(negedge clk);
        chk(req_ready, "R1 idle before request", req_ready, 1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        mem_ready = 1'b0;
        @(posedge clk);
        cyc = 0;
        strobe_clks = 0;
        done_seen = 0;
        while (!done_seen && cyc < WAIT_LIMIT + 8) begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
            if (rsp_done) begin
                done_seen = 1;
                chk(cyc == exp_len(stalls), wr ? "R3/R4/R7 cycle length" : "R2/R4/R7 cycle length",
                    cyc, exp_len(stalls));
                chk(!bus_rd && !bus_wr, "R5 strobes low at finish", {bus_rd, bus_wr}, 0);
                chk(rsp_err == (stalls >= WAIT_LIMIT), "R7 error flag", rsp_err, stalls >= WAIT_LIMIT);
                chk(bus_addr == a, "R8 address in finish", bus_addr, a);
                if (!wr && stalls < WAIT_LIMIT)
                    chk(rsp_rdata == mem_word(a), "R4/R6 read data", rsp_rdata, mem_word(a));
                else
                    chk(rsp_rdata == '0, "R6 zero data for write/abort", rsp_rdata, 0);
                if (wr && stalls == 0) chk(strobe_clks == 2, "R3 write strobe width", strobe_clks, 2);
                if (!wr && stalls == 0) chk(strobe_clks == 2, "R2 read strobe width", strobe_clks, 2);
            end else begin
                if (bus_rd || bus_wr) strobe_clks++;
                chk(bus_rd == !wr && bus_wr == wr, "R5 strobe per op", {bus_rd, bus_wr}, {!wr, wr});
                chk(bus_addr == a, "R8 address held", bus_addr, a);
                chk(bus_wdata == (wr ? d : '0), "R8 write data bus", bus_wdata, wr ? d : '0);
                chk(!req_ready, "R1 busy not ready", req_ready, 0);
                if (cyc == 1) begin
                    mem_ready = early_rdy;
                    mem_rdata = early_rdy ? ~mem_word(a) : '0;
                    if (poke) begin
                        req_valid = 1'b1;
                        req_addr  = ~a;
                    end
                end else begin
                    mem_ready = (cyc - 2) >= stalls;
                    mem_rdata = mem_ready ? mem_word(a) : ~mem_word(a);
                end
            end
        end
        if (!done_seen) chk(0, "R2/R3 done never seen", 0, 1);
        mem_ready = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        chk(!rsp_done, "R6 done single clock", rsp_done, 0);
        chk(req_ready && !bus_rd && !bus_wr, "R1 back to idle, no extra cycle",
            {req_ready, bus_rd, bus_wr}, 3'b100);
        chk(bus_addr == '0 && bus_wdata == '0, "R8 idle buses zero", bus_addr, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        rst = 1'b1;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr = '0;
        req_wdata = '0;
        mem_ready = 1'b1;
        mem_rdata = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!bus_rd && !bus_wr, "R5 strobes low in reset", {bus_rd, bus_wr}, 0);
        chk(!rsp_done && !rsp_err, "R6 no done in reset", rsp_done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", req_ready, 1);

        run_op(0, 16'h1234, 32'h0, 0, 0, 0);                 // R2
        run_op(1, 16'h0042, 32'hDEADBEEF, 0, 0, 0);          // R3
        run_op(0, 16'h00F0, 32'h0, 3, 0, 0);                 // R4
        run_op(1, 16'h7777, 32'h01234567, 2, 1, 0);          // R9 with write
        run_op(0, 16'h2468, 32'h0, 0, 1, 0);                 // R9 ready in setup
        run_op(0, 16'hABCD, 32'h0, 2, 0, 1);                 // R1 poke while busy
        run_op(0, 16'h1111, 32'h0, WAIT_LIMIT - 1, 0, 0);    // R7 one short
        run_op(0, 16'h2222, 32'h0, WAIT_LIMIT, 0, 0);        // R7 abort read
        run_op(1, 16'h3333, 32'hCAFEF00D, WAIT_LIMIT, 0, 0); // R7 abort write
        run_op(0, 16'h4444, 32'h0, 0, 0, 0);                 // R7 err clears

        for (int i = 0; i < 40; i++) begin
            int st;
            st = ($urandom % 8 == 0) ? WAIT_LIMIT + 2 : int'($urandom % 6);
            run_op(bit'($urandom % 2), ADDR_W'($urandom), $urandom, st,
                   bit'($urandom % 2), bit'($urandom % 4 == 0));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule